// File: doc/BRIEF.md
# Sub-Second Real-Time Clock with Alarms

This block keeps time with two chained counters that run from a slow 32.768 kHz clock. A 15-bit fraction counter advances once per slow cycle and wraps every 32768 counts, about 30.5 µs per count. Each wrap carries into a seconds counter. Each counter has its own run bit, and each has an alarm that can fire on one specific value or on every step. The sticky alarm flags, gated by per-alarm enables, drive a single interrupt line.

Software reaches the block through a simple write port and a combinational read port in a fast bus clock domain. A write is held in the bus domain and handed to the slow domain with a toggle handshake. Two busy bits show that a write is still crossing: one for any register, one for the control register. A write that arrives while busy is dropped. Counter values, control bits and flags come back as one snapshot. The slow domain publishes the snapshot every slow cycle and the bus domain captures it whole. The fraction and seconds values read back therefore always belong to the same instant.

Register map (word addresses): 0 control, 1 status (read), 2 flag clear (write), 3 fraction counter, 4 seconds counter, 5 fraction alarm (write), 6 seconds alarm (write). Control bits: 0 fraction run, 1 seconds run, 2 fraction interrupt enable, 3 seconds interrupt enable, 4 zero counters (acts once, reads back as 0). Status bits: 0 fraction flag, 1 seconds flag, 2 control write busy, 3 any write busy. Clear bits: 0 fraction flag, 1 seconds flag. Alarm registers: value in the low bits, step mode in bit 31 (1 = fire on every step, 0 = fire on a value match).

Top module: `sub_second_rtc`

## Requirements
- R1: After reset, the control, status, fraction and seconds registers read 0 and irq is low.
- R2: The fraction counter advances by one per slow cycle while control bit 0 is set, and holds its value while that bit is clear.
- R3: When the fraction counter steps from 32767 to 0 with seconds run (control bit 1) set, the seconds counter increments on that same slow cycle.
- R4: While control bit 1 is clear, the seconds counter holds even when the fraction counter wraps.
- R5: With alarm bit 31 clear, an alarm flag sets only when its counter steps onto the programmed value. Loading that value by a write does not set it.
- R6: With alarm bit 31 set, an alarm flag sets on every step of its counter, whatever the programmed value.
- R7: irq is high exactly when the fraction flag is set with control bit 2 set, or the seconds flag is set with control bit 3 set.
- R8: Writing clear bit 0 clears only the fraction flag; clear bit 1 clears only the seconds flag.
- R9: After an accepted write, status bit 3 is set until the slow domain has applied it. Status bit 2 is also set if the write targets the control register. A write issued while status bit 3 is set is ignored.
- R10: Writing control bit 4 zeroes both counters, and bit 4 reads back as 0.
- R11: A counter written while stopped reads back the written value and counts onward from it once restarted.
- R12: A fraction value that has wrapped is never read together with the seconds value from before the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Fast register-interface clock |
| lf_clk | input | 1 | 32.768 kHz timekeeping clock |
| rst | input | 1 | Synchronous active-high reset (resynchronized to lf_clk inside) |
| wr_en | input | 1 | Register write strobe, one bus cycle |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational from the bus-side snapshot |
| irq | output | 1 | Interrupt: enabled alarm flag set |

## Verification
Assertions in the slow domain check on every cycle that the counters hold when their run bit is clear and no write lands, that a fraction wrap with seconds running increments the seconds counter in the same cycle, and that a flag rising corresponds to a step onto the alarm value or a step in step mode. In the bus domain they check that busy is raised only by a write and that each write reaches the slow domain as a single pulse. The end-to-end effects across the two clock domains can only be shown by the bench scenarios: dropped writes while busy, preload-and-resume, coherent fraction and seconds pairs sampled across a wrap, the zero-counters bit, interrupt gating, and independent flag clearing.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int SUB_W    = 15;
    localparam int DATA_W   = 32;
    localparam int SEC_W    = DATA_W - 1;
    localparam int ADDR_W   = 3;
    localparam int MODE_BIT = DATA_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_STAT    = 3'd1,
        REG_CLR     = 3'd2,
        REG_SUB     = 3'd3,
        REG_SEC     = 3'd4,
        REG_SUB_ALM = 3'd5,
        REG_SEC_ALM = 3'd6,
        REG_NONE    = 3'd7
    } reg_addr_e;

    // bit 0 is sub_run, bit 4 is zero
    typedef struct packed {
        logic zero;
        logic sec_ie;
        logic sub_ie;
        logic sec_run;
        logic sub_run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        reg_addr_e         addr;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
        ctrl_t            ctrl;
        logic             sec_flag;
        logic             sub_flag;
    } view_t;

    function automatic ctrl_t decode_ctrl(input logic [DATA_W-1:0] d);
        return ctrl_t'(d[CTRL_W-1:0]);
    endfunction

endpackage

// File: rtl/rtc_wr_bridge.sv
module rtc_wr_bridge
    import rtc_pkg::*;
(
    input  logic    bus_clk,
    input  logic    bus_rst,
    input  logic    lf_clk,
    input  logic    lf_rst,
    input  logic    bus_wr,
    input  wr_cmd_t bus_cmd,
    output logic    busy_any,
    output logic    busy_ctrl,
    output logic    lf_cmd_vld,
    output wr_cmd_t lf_cmd
);

    wr_cmd_t    hold_q;
    logic       req_q;
    logic [1:0] ack_sync;
    logic [2:0] req_sync;

    // bus side: capture, toggle request, wait for echo
    always_comb begin
        busy_any  = (req_q != ack_sync[1]);
        busy_ctrl = busy_any && (hold_q.addr == REG_CTRL);
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            hold_q   <= '0;
            req_q    <= 1'b0;
            ack_sync <= '0;
        end else begin
            ack_sync <= {ack_sync[0], req_sync[2]};
            if (bus_wr && !busy_any) begin
                hold_q <= bus_cmd;
                req_q  <= ~req_q;
            end
        end
    end

    // slow side: edge of synchronized request applies the held command
    always_ff @(posedge lf_clk) begin
        if (lf_rst) req_sync <= '0;
        else        req_sync <= {req_sync[1:0], req_q};
    end

    always_comb begin
        lf_cmd_vld = req_sync[2] ^ req_sync[1];
        lf_cmd     = hold_q;
    end

    assert_busy_cause_R9: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $rose(busy_any) |-> $past(bus_wr));

    assert_single_apply_R9: assert property (@(posedge lf_clk) disable iff (lf_rst)
        lf_cmd_vld |=> !lf_cmd_vld);

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
(
    input  logic    lf_clk,
    input  logic    lf_rst,
    input  logic    cmd_vld,
    input  wr_cmd_t cmd,
    output view_t   view
);

    localparam logic [SUB_W-1:0] SUB_TOP = '1;

    logic [SUB_W-1:0] sub_q, sub_alm_q, sub_inc;
    logic [SEC_W-1:0] sec_q, sec_alm_q, sec_inc;
    logic             sub_alm_step_q, sec_alm_step_q;
    logic             sub_flag_q, sec_flag_q;
    ctrl_t            ctrl_q, ctrl_wr;
    logic w_ctrl, w_clr, w_sub, w_sec, w_sub_alm, w_sec_alm;
    logic zero_cnt, sub_step, sec_step, sub_hit, sec_hit;

    always_comb begin
        w_ctrl    = cmd_vld && (cmd.addr == REG_CTRL);
        w_clr     = cmd_vld && (cmd.addr == REG_CLR);
        w_sub     = cmd_vld && (cmd.addr == REG_SUB);
        w_sec     = cmd_vld && (cmd.addr == REG_SEC);
        w_sub_alm = cmd_vld && (cmd.addr == REG_SUB_ALM);
        w_sec_alm = cmd_vld && (cmd.addr == REG_SEC_ALM);
        ctrl_wr   = decode_ctrl(cmd.data);
        zero_cnt  = w_ctrl && ctrl_wr.zero;
        sub_inc   = sub_q + 1'b1;
        sec_inc   = sec_q + 1'b1;
        sub_step  = ctrl_q.sub_run && !w_sub && !zero_cnt;
        // carry in the same cycle the fraction wraps
        sec_step  = sub_step && (sub_q == SUB_TOP) && ctrl_q.sec_run && !w_sec;
        sub_hit   = sub_step && (sub_alm_step_q || (sub_inc == sub_alm_q));
        sec_hit   = sec_step && (sec_alm_step_q || (sec_inc == sec_alm_q));
    end

    always_ff @(posedge lf_clk) begin
        if (lf_rst) begin
            sub_q          <= '0;
            sec_q          <= '0;
            sub_alm_q      <= '0;
            sec_alm_q      <= '0;
            sub_alm_step_q <= 1'b0;
            sec_alm_step_q <= 1'b0;
            sub_flag_q     <= 1'b0;
            sec_flag_q     <= 1'b0;
            ctrl_q         <= '0;
        end else begin
            if (w_ctrl) begin
                ctrl_q      <= ctrl_wr;
                ctrl_q.zero <= 1'b0;
            end
            if (zero_cnt) begin
                sub_q <= '0;
                sec_q <= '0;
            end else begin
                if (w_sub)         sub_q <= cmd.data[SUB_W-1:0];
                else if (sub_step) sub_q <= sub_inc;
                if (w_sec)         sec_q <= cmd.data[SEC_W-1:0];
                else if (sec_step) sec_q <= sec_inc;
            end
            if (w_sub_alm) begin
                sub_alm_q      <= cmd.data[SUB_W-1:0];
                sub_alm_step_q <= cmd.data[MODE_BIT];
            end
            if (w_sec_alm) begin
                sec_alm_q      <= cmd.data[SEC_W-1:0];
                sec_alm_step_q <= cmd.data[MODE_BIT];
            end
            sub_flag_q <= (sub_flag_q && !(w_clr && cmd.data[0])) || sub_hit;
            sec_flag_q <= (sec_flag_q && !(w_clr && cmd.data[1])) || sec_hit;
        end
    end

    always_comb begin
        view.sec      = sec_q;
        view.sub      = sub_q;
        view.ctrl     = ctrl_q;
        view.sec_flag = sec_flag_q;
        view.sub_flag = sub_flag_q;
    end

    assert_sub_hold_R2: assert property (@(posedge lf_clk) disable iff (lf_rst)
        (!ctrl_q.sub_run && !cmd_vld) |=> $stable(sub_q));

    assert_carry_R3: assert property (@(posedge lf_clk) disable iff (lf_rst)
        (ctrl_q.sub_run && ctrl_q.sec_run && sub_q == SUB_TOP && !cmd_vld)
        |=> (sub_q == '0 && sec_q == $past(sec_q) + 1'b1));

    assert_sec_hold_R4: assert property (@(posedge lf_clk) disable iff (lf_rst)
        (!ctrl_q.sec_run && !cmd_vld) |=> $stable(sec_q));

    assert_match_R5: assert property (@(posedge lf_clk) disable iff (lf_rst)
        ($rose(sub_flag_q) && !$past(sub_alm_step_q)) |-> (sub_q == $past(sub_alm_q)));

    assert_step_R6: assert property (@(posedge lf_clk) disable iff (lf_rst)
        $rose(sub_flag_q) |-> (sub_q != $past(sub_q)));

    assert_clear_R8: assert property (@(posedge lf_clk) disable iff (lf_rst)
        (w_clr && cmd.data[0] && !sub_hit) |=> !sub_flag_q);

endmodule

// File: rtl/rtc_view_sync.sv
module rtc_view_sync
    import rtc_pkg::*;
(
    input  logic  lf_clk,
    input  logic  lf_rst,
    input  logic  bus_clk,
    input  logic  bus_rst,
    input  view_t lf_view,
    output view_t bus_view
);

    view_t      shadow_q, bus_q;
    logic       tog_q;
    logic [2:0] tog_sync;

    // republished every slow cycle; stable for a full slow period after the toggle
    always_ff @(posedge lf_clk) begin
        if (lf_rst) begin
            shadow_q <= '0;
            tog_q    <= 1'b0;
        end else begin
            shadow_q <= lf_view;
            tog_q    <= ~tog_q;
        end
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            tog_sync <= '0;
            bus_q    <= '0;
        end else begin
            tog_sync <= {tog_sync[1:0], tog_q};
            if (tog_sync[2] ^ tog_sync[1]) bus_q <= shadow_q;
        end
    end

    always_comb bus_view = bus_q;

endmodule

// File: rtl/sub_second_rtc.sv
module sub_second_rtc
    import rtc_pkg::*;
(
    input  logic              bus_clk,
    input  logic              lf_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic [1:0] lf_rst_pipe;
    logic       lf_rst;
    logic       busy_any, busy_ctrl, lf_cmd_vld;
    wr_cmd_t    bus_cmd, lf_cmd;
    view_t      lf_view, bus_view;

    always_ff @(posedge lf_clk) lf_rst_pipe <= {lf_rst_pipe[0], rst};
    always_comb lf_rst = lf_rst_pipe[1];

    always_comb begin
        bus_cmd.addr = reg_addr_e'(wr_addr);
        bus_cmd.data = wr_data;
    end

    rtc_wr_bridge u_bridge (
        .bus_clk    (bus_clk),
        .bus_rst    (rst),
        .lf_clk     (lf_clk),
        .lf_rst     (lf_rst),
        .bus_wr     (wr_en),
        .bus_cmd    (bus_cmd),
        .busy_any   (busy_any),
        .busy_ctrl  (busy_ctrl),
        .lf_cmd_vld (lf_cmd_vld),
        .lf_cmd     (lf_cmd)
    );

    rtc_core u_core (
        .lf_clk  (lf_clk),
        .lf_rst  (lf_rst),
        .cmd_vld (lf_cmd_vld),
        .cmd     (lf_cmd),
        .view    (lf_view)
    );

    rtc_view_sync u_view (
        .lf_clk   (lf_clk),
        .lf_rst   (lf_rst),
        .bus_clk  (bus_clk),
        .bus_rst  (rst),
        .lf_view  (lf_view),
        .bus_view (bus_view)
    );

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            REG_CTRL: rd_data = DATA_W'(bus_view.ctrl);
            REG_STAT: rd_data = DATA_W'({busy_any, busy_ctrl,
                                         bus_view.sec_flag, bus_view.sub_flag});
            REG_SUB:  rd_data = DATA_W'(bus_view.sub);
            REG_SEC:  rd_data = DATA_W'(bus_view.sec);
            default:  rd_data = '0;
        endcase
        irq = (bus_view.sub_flag && bus_view.ctrl.sub_ie) ||
              (bus_view.sec_flag && bus_view.ctrl.sec_ie);
    end

endmodule

// File: tb/tb_sub_second_rtc.sv
module tb_sub_second_rtc;

    localparam int BUS_PERIOD = 10;
    localparam int LF_PERIOD  = 100;
    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CLR = 3'd2,
                           A_SUB = 3'd3, A_SEC = 3'd4, A_SUBALM = 3'd5, A_SECALM = 3'd6;

    logic        bus_clk = 1'b0, lf_clk = 1'b0, rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;
    int          checks = 0, errors = 0;

    sub_second_rtc dut (
        .bus_clk (bus_clk), .lf_clk (lf_clk), .rst (rst),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data), .irq (irq)
    );

    always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
    always #(LF_PERIOD/2)  lf_clk  = ~lf_clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input logic [31:0] act,
                           input logic [31:0] lo, input logic [31:0] hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge bus_clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(A_STAT, s);
            if (!s[3]) break;
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge lf_clk);
    endtask

    task automatic issue(input logic [2:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        issue(a, d);
        wait_idle();
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_SUB, v);  chk("R1 fraction", v, 0);
        rd(A_SEC, v);  chk("R1 seconds", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic test_run_stop();
        logic [31:0] a, b;
        rd(A_SUB, a);
        repeat (20) @(posedge lf_clk);
        rd(A_SUB, b); chk("R2 stopped holds", b, a);
        bus_wr(A_CTRL, 32'h1); settle();
        rd(A_SUB, a);
        repeat (20) @(posedge lf_clk);
        rd(A_SUB, b); chk_rng("R2 running advance", b - a, 18, 22);
        bus_wr(A_CTRL, 32'h0); settle();
        rd(A_SUB, a);
        repeat (10) @(posedge lf_clk);
        rd(A_SUB, b); chk("R2 stopped again", b, a);
    endtask

    task automatic test_busy();
        logic [31:0] v;
        issue(A_CTRL, 32'h0);
        rd(A_STAT, v); chk("R9 ctrl write busy bits", v[3:2], 2'b11);
        wait_idle();
        rd(A_STAT, v); chk("R9 busy cleared", v[3:2], 2'b00);
        issue(A_SUB, 32'd50);
        rd(A_STAT, v); chk("R9 non-ctrl write busy bits", v[3:2], 2'b10);
        wait_idle();
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = A_SUB; wr_data = 32'd1000;
        @(negedge bus_clk);
        wr_data = 32'd2000;
        @(negedge bus_clk);
        wr_en = 1'b0;
        wait_idle(); settle();
        rd(A_SUB, v); chk("R9 write while busy dropped", v, 1000);
    endtask

    task automatic test_wrap();
        logic [31:0] s, c;
        bit bad = 0;
        bus_wr(A_SUB, 32'd32763);
        bus_wr(A_SEC, 32'd7);
        settle();
        rd(A_SUB, s); chk("R11 fraction preload", s, 32763);
        rd(A_SEC, c); chk("R11 seconds preload", c, 7);
        bus_wr(A_CTRL, 32'h3);
        for (int i = 0; i < 300; i++) begin
            @(negedge bus_clk);
            rd_addr = A_SUB; #1 s = rd_data;
            rd_addr = A_SEC; #1 c = rd_data;
            if (!((c == 7 && s >= 32763) || (c == 8 && s <= 100))) bad = 1;
        end
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL R12: actual sec %0d frac %0d expected coherent pair", c, s);
        end
        bus_wr(A_CTRL, 32'h0); settle();
        rd(A_SEC, c); chk("R3 carry into seconds", c, 8);
        rd(A_SUB, s); chk_rng("R11 counted onward after wrap", s, 10, 60);
    endtask

    task automatic test_sec_hold();
        logic [31:0] v;
        bus_wr(A_SUB, 32'd32766);
        bus_wr(A_SEC, 32'd3);
        bus_wr(A_CTRL, 32'h1);
        repeat (15) @(posedge lf_clk);
        bus_wr(A_CTRL, 32'h0); settle();
        rd(A_SEC, v); chk("R4 seconds held while stopped", v, 3);
        rd(A_SUB, v); chk_rng("R4 fraction wrapped", v, 1, 40);
    endtask

    task automatic test_zero();
        logic [31:0] v;
        bus_wr(A_CTRL, 32'h10); settle();
        rd(A_SUB, v);  chk("R10 fraction zeroed", v, 0);
        rd(A_SEC, v);  chk("R10 seconds zeroed", v, 0);
        rd(A_CTRL, v); chk("R10 zero bit not kept", v, 0);
    endtask

    task automatic test_match();
        logic [31:0] v;
        bus_wr(A_CLR, 32'h3);
        bus_wr(A_SUBALM, 32'd130);
        bus_wr(A_SUB, 32'd130);
        settle();
        rd(A_STAT, v); chk("R5 load of alarm value no flag", v[0], 0);
        bus_wr(A_SUB, 32'd100);
        bus_wr(A_CTRL, 32'h5); settle();
        rd(A_STAT, v); chk("R5 before match", v[1:0], 2'b00);
        chk("R7 irq low before match", {31'd0, irq}, 0);
        repeat (40) @(posedge lf_clk);
        rd(A_STAT, v); chk("R5 flag after match", v[1:0], 2'b01);
        chk("R7 irq with enabled flag", {31'd0, irq}, 1);
    endtask

    task automatic test_step_clear();
        logic [31:0] v;
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_CLR, 32'h3);
        bus_wr(A_SECALM, 32'h8000_03E8);
        bus_wr(A_SUB, 32'd32760);
        bus_wr(A_CTRL, 32'h3);
        repeat (20) @(posedge lf_clk);
        bus_wr(A_CTRL, 32'h0); settle();
        rd(A_STAT, v); chk("R6 seconds step-mode flag only", v[1:0], 2'b10);
        chk("R7 irq low with enables off", {31'd0, irq}, 0);
        bus_wr(A_SUBALM, 32'h8000_0000);
        bus_wr(A_CTRL, 32'h1);
        repeat (3) @(posedge lf_clk);
        bus_wr(A_CTRL, 32'h0); settle();
        rd(A_STAT, v); chk("R6 fraction step-mode flag", v[1:0], 2'b11);
        bus_wr(A_CLR, 32'h1); settle();
        rd(A_STAT, v); chk("R8 clear fraction only", v[1:0], 2'b10);
        bus_wr(A_CTRL, 32'h4); settle();
        chk("R7 irq gated by other enable", {31'd0, irq}, 0);
        bus_wr(A_CTRL, 32'h8); settle();
        chk("R7 irq from seconds flag", {31'd0, irq}, 1);
        bus_wr(A_CLR, 32'h2); settle();
        rd(A_STAT, v); chk("R8 clear seconds", v[1:0], 2'b00);
        chk("R8 irq drops after clear", {31'd0, irq}, 0);
    endtask

    initial begin
        repeat (8) @(posedge lf_clk);
        @(negedge bus_clk);
        rst = 1'b0;
        settle();
        test_reset();
        test_run_stop();
        test_busy();
        test_wrap();
        test_sec_hold();
        test_zero();
        test_match();
        test_step_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule